// File: doc/BRIEF.md
# Digital Constant-Fraction Pulse Timer

This block takes one digitised pulse window, sample by sample, as it is read out of a waveform buffer. It returns a time of arrival finer than one sample. The time is the point where the pulse first rises through a fixed fraction of its own amplitude. Because the threshold scales with each pulse's peak, pulses of the same shape give the same time whatever their size, so there is no amplitude-dependent walk.

The leading eight samples of the window give the baseline, which is their average. That baseline is subtracted from every sample. The largest sample of the window, less the baseline, is the peak. A pulse whose peak stays under an event level is rejected without timing. The whole window is stored, so the peak is known before any crossing is sought. The search then walks the stored samples from index 8 and stops at the first pair that brackets the threshold. A sequential divider interpolates linearly between those two samples to give eight fractional bits. A build-time variant replaces the general multiplier by a right shift when the fraction is a power of two.

The control is one state machine. ST_IDLE goes to ST_ACQ on the first sample, or to ST_DONE when that sample is also the last. ST_ACQ goes to ST_THR on the last sample, or to ST_DONE when the window is too short. ST_THR goes to ST_SCAN, or to ST_DONE when the event level is not met. ST_SCAN goes to ST_DIV on a crossing, or to ST_DONE when the window ends without one. ST_DIV goes to ST_DONE when the quotient is ready. ST_DONE always returns to ST_IDLE. A new window may start only after the result pulse has appeared. `frac_mult` and `evt_level` must hold steady from the first sample until that result.

Top module: `cfd_timing_disc`

## Requirements
- R1: After reset, `t_valid` and `t_err` are low.
- R2: The baseline is floor(sum of samples 0..7 / 8), and every sample used for timing is the raw value minus this baseline, as a signed number.
- R3: When the peak (largest raw sample minus baseline) is below `evt_level`, the result is `t_err`, one cycle after the last sample is taken.
- R4: The timing threshold is floor(peak × `frac_mult` / 256).
- R5: The crossing is the first index k, searched upward from 8, with y[k-1] < threshold <= y[k].
- R6: `t_time` = (k-1)·256 + floor(256·(threshold − y[k-1]) / (y[k] − y[k-1])). The value is 14 bits with the low 8 bits fractional. An exact hit y[k] = threshold gives k·256.
- R7: When no index satisfies R5, the result is `t_err`, (L+1−8) cycles after the last sample is taken, where L is the stored window length.
- R8: A window of 8 or fewer samples gives `t_err` in the cycle right after its last sample is taken.
- R9: A timed result is a one-cycle `t_valid` pulse, (12 + k − 8) cycles after the last sample is taken. `t_valid` and `t_err` are never high together, and each lasts one cycle.
- R10: Only the first 64 samples of a window are stored. Later samples, up to the one marked last, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is present this cycle |
| in_sample | input | 12 | Unsigned raw sample |
| in_last | input | 1 | Marks the final sample of the window |
| frac_mult | input | 8 | Fraction numerator, scaled by 1/256 |
| evt_level | input | 12 | Least peak that counts as an event |
| t_valid | output | 1 | One-cycle pulse with a timed result |
| t_err | output | 1 | One-cycle pulse when no time can be given |
| t_time | output | 14 | Arrival time in samples, 8 fractional bits; zero when t_valid is low |

## Verification
The block can meet its peak, its threshold crossing and the end of its window on one and the same sample. In a monotonically rising window the last sample is at once the maximum, the sample that closes the bracket, and the sample that ends the stream. This case is driven, and the bench checks that the crossing is still found at the final index, at the predicted latency. A second case arranges for the crossing sample to equal the threshold exactly, so the interpolation quotient reaches its full value of 256 and carries into the integer part. The bench model predicts every cycle of `t_valid` and `t_err` around each result, so any early, late or doubled pulse is reported.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_THR,
        ST_SCAN,
        ST_DIV,
        ST_DONE
    } cfd_state_e;

endpackage

// File: rtl/cfd_capture.sv
module cfd_capture #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 64,
    parameter int BASE_N   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic                                   wr_en,
    input  logic [SAMPLE_W-1:0]                    wr_data,
    input  logic [$clog2(DEPTH)-1:0]               rd_idx,
    output logic [SAMPLE_W-1:0]                    rd_data,
    output logic [$clog2(DEPTH):0]                 count,
    output logic [SAMPLE_W+$clog2(BASE_N)-1:0]     sum,
    output logic [SAMPLE_W-1:0]                    max_raw
);
    localparam int IW   = $clog2(DEPTH);
    localparam int CW   = IW + 1;
    localparam int SUMW = SAMPLE_W + $clog2(BASE_N);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic                room;

    assign room    = (count < CW'(DEPTH));
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            sum     <= '0;
            max_raw <= '0;
        end else if (start) begin
            count   <= CW'(1);
            sum     <= SUMW'(wr_data);
            max_raw <= wr_data;
        end else if (wr_en && room) begin
            count <= count + 1'b1;
            if (count < CW'(BASE_N))
                sum <= sum + SUMW'(wr_data);
            if (wr_data > max_raw)
                max_raw <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (start)
            mem[0] <= wr_data;
        else if (wr_en && room)
            mem[count[IW-1:0]] <= wr_data;
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && !start) |=> $stable(max_raw));

endmodule

// File: rtl/cfd_threshold.sv
module cfd_threshold #(
    parameter int SAMPLE_W   = 12,
    parameter int BASE_N     = 8,
    parameter int FRAC_W     = 8,
    parameter int SHIFT_MODE = 0,
    parameter int SHIFT_AMT  = 2
) (
    input  logic [SAMPLE_W+$clog2(BASE_N)-1:0] sum,
    input  logic [SAMPLE_W-1:0]                max_raw,
    input  logic [FRAC_W-1:0]                  frac,
    output logic [SAMPLE_W-1:0]                base,
    output logic [SAMPLE_W-1:0]                peak,
    output logic [SAMPLE_W-1:0]                thr
);
    localparam int LOGB = $clog2(BASE_N);
    localparam int PW   = SAMPLE_W + FRAC_W;

    assign base = sum[SAMPLE_W+LOGB-1:LOGB];
    assign peak = max_raw - base;

    generate
        if (SHIFT_MODE != 0) begin : g_shift
            logic [FRAC_W-1:0] frac_unused;
            assign frac_unused = frac;
            assign thr = peak >> SHIFT_AMT;
        end else begin : g_mult
            logic [PW-1:0] prod;
            assign prod = PW'(peak) * PW'(frac);
            assign thr  = prod[PW-1:FRAC_W];
        end
    endgenerate

endmodule

// File: rtl/cfd_divider.sv
module cfd_divider #(
    parameter int NW = 13,
    parameter int QW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [NW-1:0] den,
    output logic          done,
    output logic [QW-1:0] quot
);
    localparam int CNTW = $clog2(QW) + 1;

    logic [NW-1:0]   rem_q;
    logic [NW-1:0]   den_q;
    logic [QW-1:0]   q_q;
    logic [CNTW-1:0] cnt_q;
    logic            running_q;
    logic            done_q;
    logic [NW:0]     sh;

    // first step compares the numerator itself, later steps shift left
    always_comb begin
        if (cnt_q == '0)
            sh = {1'b0, rem_q};
        else
            sh = {rem_q, 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            den_q     <= '0;
            q_q       <= '0;
            cnt_q     <= '0;
            running_q <= 1'b0;
            done_q    <= 1'b0;
        end else if (start) begin
            rem_q     <= num;
            den_q     <= den;
            q_q       <= '0;
            cnt_q     <= '0;
            running_q <= 1'b1;
            done_q    <= 1'b0;
        end else if (running_q) begin
            if (sh >= {1'b0, den_q}) begin
                rem_q <= NW'(sh - {1'b0, den_q});
                q_q   <= {q_q[QW-2:0], 1'b1};
            end else begin
                rem_q <= sh[NW-1:0];
                q_q   <= {q_q[QW-2:0], 1'b0};
            end
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNTW'(QW-1)) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign quot = q_q;

    assert_den_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (den_q != '0));

    assert_quot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (q_q <= QW'(1 << (QW-1))));

endmodule

// File: rtl/cfd_timing_disc.sv
module cfd_timing_disc
    import cfd_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int WIN_DEPTH  = 64,
    parameter int BASE_N     = 8,
    parameter int FRAC_W     = 8,
    parameter int SHIFT_MODE = 0,
    parameter int SHIFT_AMT  = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [SAMPLE_W-1:0]                   in_sample,
    input  logic                                  in_last,
    input  logic [FRAC_W-1:0]                     frac_mult,
    input  logic [SAMPLE_W-1:0]                   evt_level,
    output logic                                  t_valid,
    output logic                                  t_err,
    output logic [$clog2(WIN_DEPTH)+FRAC_W-1:0]   t_time
);
    localparam int IW   = $clog2(WIN_DEPTH);
    localparam int CW   = IW + 1;
    localparam int YW   = SAMPLE_W + 1;
    localparam int TW   = IW + FRAC_W;
    localparam int QW   = FRAC_W + 1;
    localparam int SUMW = SAMPLE_W + $clog2(BASE_N);

    cfd_state_e state_q, state_d;
    logic       err_q, err_d;

    logic [CW-1:0]          idx_q, cross_q, len_w, len_next, crossm1;
    logic signed [YW-1:0]   prev_q, cur, thr_s;
    logic [SAMPLE_W-1:0]    base_q, thr_q, base_use;
    logic [TW-1:0]          time_q;

    logic                   cap_start, cap_wr;
    logic [IW-1:0]          rd_idx;
    logic [SAMPLE_W-1:0]    rd_data, max_raw, base_w, peak_w, thr_w;
    logic [SUMW-1:0]        sum_w;
    logic                   hit, div_start, div_done;
    logic [YW-1:0]          num_w, den_w;
    logic [QW-1:0]          quot;

    assign cap_start = in_valid && (state_q == ST_IDLE);
    assign cap_wr    = in_valid && (state_q == ST_ACQ);
    assign rd_idx    = (state_q == ST_THR) ? IW'(BASE_N - 1) : idx_q[IW-1:0];

    cfd_capture #(.SAMPLE_W(SAMPLE_W), .DEPTH(WIN_DEPTH), .BASE_N(BASE_N)) u_cap (
        .clk(clk), .rst_n(rst_n), .start(cap_start), .wr_en(cap_wr),
        .wr_data(in_sample), .rd_idx(rd_idx), .rd_data(rd_data),
        .count(len_w), .sum(sum_w), .max_raw(max_raw)
    );

    cfd_threshold #(.SAMPLE_W(SAMPLE_W), .BASE_N(BASE_N), .FRAC_W(FRAC_W),
                    .SHIFT_MODE(SHIFT_MODE), .SHIFT_AMT(SHIFT_AMT)) u_thr (
        .sum(sum_w), .max_raw(max_raw), .frac(frac_mult),
        .base(base_w), .peak(peak_w), .thr(thr_w)
    );

    // baseline-corrected sample at the read pointer
    assign base_use = (state_q == ST_THR) ? base_w : base_q;
    assign cur      = $signed({1'b0, rd_data}) - $signed({1'b0, base_use});
    assign thr_s    = $signed({1'b0, thr_q});
    assign hit      = (prev_q < thr_s) && (cur >= thr_s);
    assign num_w    = $unsigned(thr_s - prev_q);
    assign den_w    = $unsigned(cur - prev_q);
    assign div_start = (state_q == ST_SCAN) && hit;
    assign len_next = (len_w < CW'(WIN_DEPTH)) ? len_w + 1'b1 : len_w;
    assign crossm1  = cross_q - 1'b1;

    cfd_divider #(.NW(YW), .QW(QW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(num_w), .den(den_w), .done(div_done), .quot(quot)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) begin
                if (in_last) begin
                    state_d = ST_DONE;
                    err_d   = 1'b1;
                end else begin
                    state_d = ST_ACQ;
                end
            end
            ST_ACQ: if (in_valid && in_last) begin
                if (len_next <= CW'(BASE_N)) begin
                    state_d = ST_DONE;
                    err_d   = 1'b1;
                end else begin
                    state_d = ST_THR;
                end
            end
            ST_THR: begin
                if (peak_w < evt_level) begin
                    state_d = ST_DONE;
                    err_d   = 1'b1;
                end else begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (hit) begin
                    state_d = ST_DIV;
                end else if (idx_q == len_w - 1'b1) begin
                    state_d = ST_DONE;
                    err_d   = 1'b1;
                end
            end
            ST_DIV: if (div_done) begin
                state_d = ST_DONE;
                err_d   = 1'b0;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
                err_d   = 1'b0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            cross_q <= '0;
            prev_q  <= '0;
            base_q  <= '0;
            thr_q   <= '0;
            time_q  <= '0;
        end else begin
            unique case (state_q)
                ST_THR: begin
                    base_q <= base_w;
                    thr_q  <= thr_w;
                    prev_q <= cur;
                    idx_q  <= CW'(BASE_N);
                end
                ST_SCAN: begin
                    if (hit) begin
                        cross_q <= idx_q;
                    end else begin
                        prev_q <= cur;
                        idx_q  <= idx_q + 1'b1;
                    end
                end
                ST_DIV: if (div_done)
                    time_q <= {crossm1[IW-1:0], {FRAC_W{1'b0}}} + TW'(quot);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        t_valid = (state_q == ST_DONE) && !err_q;
        t_err   = (state_q == ST_DONE) && err_q;
        t_time  = t_valid ? time_q : '0;
    end

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_valid && t_err));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (t_valid || t_err) |=> !(t_valid || t_err));

    assert_scan_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (idx_q >= CW'(BASE_N) && idx_q < len_w));

    assert_thr_le_peak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THR) |-> (thr_w <= peak_w));

    assert_div_to_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV && div_done) |=> t_valid);

endmodule

// File: tb/tb_cfd_timing_disc.sv
module tb_cfd_timing_disc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic        in_last = 1'b0;
    logic [7:0]  frac_mult = '0;
    logic [11:0] evt_level = '0;
    logic        t_valid, t_err;
    logic [13:0] t_time;

    int checks = 0;
    int errors = 0;
    int win[$];
    bit exp_ok;
    int exp_time;
    int exp_lat;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfd_timing_disc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_last(in_last), .frac_mult(frac_mult), .evt_level(evt_level),
        .t_valid(t_valid), .t_err(t_err), .t_time(t_time)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // behavioural reference from the requirements
    task automatic model(input int fr, input int ev);
        int len, base, mx, peak, thr, sum;
        len = (win.size() > 64) ? 64 : win.size();
        exp_ok = 0; exp_time = 0;
        if (len <= 8) begin exp_lat = 0; return; end
        sum = 0;
        for (int i = 0; i < 8; i++) sum += win[i];
        base = sum / 8;
        mx = 0;
        for (int i = 0; i < len; i++) if (win[i] > mx) mx = win[i];
        peak = mx - base;
        if (peak < ev) begin exp_lat = 1; return; end
        thr = (peak * fr) / 256;
        for (int k = 8; k < len; k++) begin
            int a, b;
            a = win[k-1] - base;
            b = win[k] - base;
            if (a < thr && b >= thr) begin
                exp_ok = 1;
                exp_time = (k - 1) * 256 + (256 * (thr - a)) / (b - a);
                exp_lat = 12 + k - 8;
                return;
            end
        end
        exp_lat = len + 1 - 8;
    endtask

    task automatic run_case(input string tag, input int fr, input int ev);
        model(fr, ev);
        frac_mult = 8'(fr);
        evt_level = 12'(ev);
        foreach (win[i]) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 12'(win[i]);
            in_last   = (i == win.size() - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        for (int n = 0; n <= exp_lat + 2; n++) begin
            bit at;
            if (n > 0) @(negedge clk);
            at = (n == exp_lat);
            chk(t_valid == (at && exp_ok), exp_ok ? "R9" : tag,
                $sformatf("%s t_valid cycle %0d", tag, n), int'(t_valid), int'(at && exp_ok));
            chk(t_err == (at && !exp_ok), exp_ok ? "R9" : tag,
                $sformatf("%s t_err cycle %0d", tag, n), int'(t_err), int'(at && !exp_ok));
            if (at && exp_ok)
                chk(int'(t_time) == exp_time, tag, "t_time", int'(t_time), exp_time);
        end
        win.delete();
    endtask

    task automatic add_base(input int v);
        for (int i = 0; i < 8; i++) win.push_back(v);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL R9 watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int shape[12] = '{10, 100, 400, 900, 1300, 1400, 1200, 800, 400, 150, 50, 10};
        repeat (3) @(negedge clk);
        chk(t_valid == 0 && t_err == 0, "R1", "outputs in reset", int'(t_valid | t_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(t_valid == 0 && t_err == 0, "R1", "outputs after reset", int'(t_valid | t_err), 0);

        // R2 R5 R6: noisy baseline, fraction near 0.2
        win = '{200, 202, 198, 201, 199, 200, 203, 197};
        foreach (shape[i]) win.push_back(200 + shape[i]);
        run_case("R2", 51, 300);

        // R4 R6: same shape, double amplitude (walk cancellation)
        add_base(200);
        foreach (shape[i]) win.push_back(200 + 2 * shape[i]);
        run_case("R6", 51, 300);

        // R4: half fraction
        add_base(200);
        foreach (shape[i]) win.push_back(200 + shape[i]);
        run_case("R4", 128, 300);

        // R3: below event level
        add_base(500);
        win.push_back(550); win.push_back(600); win.push_back(560); win.push_back(500);
        run_case("R3", 51, 300);

        // R8: too short
        for (int i = 0; i < 6; i++) win.push_back(100 + i);
        run_case("R8", 51, 10);

        // R8: exactly eight samples
        add_base(300);
        run_case("R8", 51, 0);

        // R7: above threshold from the start, no rising bracket
        for (int i = 0; i < 7; i++) win.push_back(100);
        for (int i = 0; i < 6; i++) win.push_back(900);
        run_case("R7", 128, 100);

        // R6: exact hit gives full quotient
        add_base(0);
        win.push_back(50); win.push_back(100); win.push_back(200);
        run_case("R6", 128, 10);

        // R5: rising ramp, peak and crossing on the final sample
        add_base(100);
        for (int j = 1; j <= 20; j++) win.push_back(100 + 40 * j);
        run_case("R5", 250, 100);

        // R5: two crossings, first one taken
        add_base(100);
        win.push_back(600); win.push_back(150); win.push_back(1100); win.push_back(300);
        run_case("R5", 100, 100);

        // R10: samples after 64 are dropped
        add_base(300);
        for (int i = 8; i < 64; i++) win.push_back((i >= 30 && i < 36) ? 300 + (i - 29) * 150 : 300);
        for (int i = 0; i < 5; i++) win.push_back(4000);
        run_case("R10", 64, 100);

        // R10: full window with late pulse cut off, so no event
        add_base(300);
        for (int i = 8; i < 64; i++) win.push_back(305);
        for (int i = 0; i < 4; i++) win.push_back(3000);
        run_case("R10", 64, 200);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule